// File: doc/BRIEF.md
# Multi-cycle Accumulator-Bus Processor Core

This block is a small 32-bit processor that runs one instruction at a time in a sequence of clock cycles. It fetches a word from an external memory, decodes it, and then carries out a ten-operation instruction set. The operations are register arithmetic and logic, register copy, load, store, branch and halt. All data moves pass through a set of internal holding registers: a program counter, an instruction register, a memory address register, a memory buffer register, two ALU operand registers and an ALU result register. The core also holds a 32-entry register file and a single zero flag.

Memory is attached through a plain synchronous port. The core presents a byte address and, for a store, write data with a one-cycle write strobe. The memory returns the addressed word on the read-data input one clock after the address is presented. Load, store and branch instructions carry their absolute operand address in a second word after the instruction word. When the core halts it raises `halted` and stays idle until reset.

Top module: `acc_bus_cpu`

## Requirements
- R1: While reset is high and after it is released, the program counter is 0, all register-file entries are 0, `halted` is low, `mem_we` is low and `mem_addr` is 0. Execution starts with the instruction word at byte address 0.
- R2: An instruction word holds the operation in bits 31:24, the first source field in 23:16, the second source field in 15:8 and the destination field in 7:0. Operation codes are ADD 0, SUB 1, NOT 2, AND 3, OR 4, MOV 5, LD 6, ST 7, branch 8 and HLT 9. `mem_addr` is a byte address: the word used is at index `mem_addr/4`, and read data is taken one clock after the address is driven.
- R3: Each instruction or operand word consumed moves the program counter forward by 4, so instructions run in address order.
- R4: ADD, SUB, AND and OR combine the first-source and second-source registers (SUB is first minus second, modulo 2^32) and write the result to the destination register.
- R5: NOT (bitwise inverse) and MOV (copy) use only the first-source register; the second-source field has no effect.
- R6: The zero flag is set when the result of an executed ADD, SUB, NOT, AND, OR, MOV or LD is 0 and cleared otherwise. Fetch, operand-address handling, ST and branches leave it unchanged.
- R7: LD reads the word at the absolute byte address held in the word following the instruction and writes it to the destination register; execution continues after that second word.
- R8: ST writes the first-source register to the absolute byte address held in the following word. It asserts `mem_we` for exactly one clock, with that address and data on the port.
- R9: A branch with condition field 0 is always taken, 1 is taken when the zero flag is set, 2 is taken when it is clear, and 3 or more is never taken. A taken branch continues at the address in the following word; a branch not taken continues after that word.
- R10: Operation code 9, or any value above 9, halts the core. `halted` then stays high, `mem_we` stays low and `mem_addr` stays constant until reset, and no later instruction runs.
- R11: Register fields select register-file entry (field mod 32), so field values of 32 or more alias lower entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Byte address presented to memory |
| mem_rdata | input | 32 | Word read at the address presented one clock earlier |
| mem_wdata | output | 32 | Data written on a store |
| mem_we | output | 1 | Write strobe, one clock per store |
| halted | output | 1 | High once a halt operation has executed |

## Verification
The hardest case to reach from the ports is a zero flag that must survive several instructions that do not touch it. A conditional branch has to see the flag from an ALU result that came before a store, a fetch and an operand-address read. The register file and flag are not visible, so test programs decide each branch and then store a result. A wrong branch lands in a trap routine that writes a marker word. The bench then checks result words and the absence of the marker in its memory model. Register aliasing and the ignored second-source field on NOT and MOV are shown the same way, by storing values that depend on them.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  typedef enum logic [7:0] {
    OP_ADD = 8'd0,
    OP_SUB = 8'd1,
    OP_NOT = 8'd2,
    OP_AND = 8'd3,
    OP_OR  = 8'd4,
    OP_MOV = 8'd5,
    OP_LD  = 8'd6,
    OP_ST  = 8'd7,
    OP_BR  = 8'd8,
    OP_HLT = 8'd9
  } op_e;

  typedef enum logic [2:0] {
    ALU_COPY,
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_NOT
  } alu_fn_e;

  // Sequencer states. Fetch: S_FA..S_FI. Operand-word handling: S_OA..S_OC2.
  typedef enum logic [4:0] {
    S_FA, S_FC, S_FW, S_FI, S_DEC,
    S_OA, S_OC, S_OW, S_OD, S_OA2, S_OC2,
    S_LW, S_LM, S_OPR, S_EXE, S_WB,
    S_SR, S_SW, S_BA, S_BC, S_HALT
  } state_e;

  localparam logic [7:0] COND_ALWAYS = 8'd0;
  localparam logic [7:0] COND_ZERO   = 8'd1;
  localparam logic [7:0] COND_NZERO  = 8'd2;

endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import cpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_sel_a,
  input  logic [IDX_W-1:0]  rd_sel_b,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);

  logic [DATA_W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_sel] <= wr_data;
    end
  end

  assign rd_a = regs[rd_sel_a];
  assign rd_b = regs[rd_sel_b];

  // A written entry reads back on the next cycle if the selector holds.
  AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_sel == rd_sel_a)) |=> (!$stable(rd_sel_a) || rd_a == $past(wr_data))); // R4

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] res,
  output logic              res_zero
);

  function automatic logic [DATA_W-1:0] alu_eval(
    input alu_fn_e           f,
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] y
  );
    case (f)
      ALU_ADD: return x + y;
      ALU_SUB: return x - y;
      ALU_AND: return x & y;
      ALU_OR:  return x | y;
      ALU_NOT: return ~x;
      default: return x;
    endcase
  endfunction

  assign res      = alu_eval(fn, opa, opb);
  assign res_zero = (res == '0);

endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] opcode,
  input  logic [7:0] cond,
  input  logic       zf,
  output state_e     state,
  output alu_fn_e    alu_fn,
  output logic       halted
);

  state_e nxt;

  function automatic logic branch_go(input logic [7:0] c, input logic z);
    case (c)
      COND_ALWAYS: return 1'b1;
      COND_ZERO:   return z;
      COND_NZERO:  return !z;
      default:     return 1'b0;
    endcase
  endfunction

  function automatic alu_fn_e exec_fn(input logic [7:0] op);
    case (op)
      OP_ADD:  return ALU_ADD;
      OP_SUB:  return ALU_SUB;
      OP_AND:  return ALU_AND;
      OP_OR:   return ALU_OR;
      OP_NOT:  return ALU_NOT;
      default: return ALU_COPY;
    endcase
  endfunction

  wire is_mem_ref = (opcode == OP_LD) || (opcode == OP_ST) || (opcode == OP_BR);
  wire is_stop    = (opcode >= OP_HLT);

  always_comb begin
    nxt = state;
    case (state)
      S_FA:  nxt = S_FC;
      S_FC:  nxt = S_FW;
      S_FW:  nxt = S_FI;
      S_FI:  nxt = S_DEC;
      S_DEC: begin
        if (is_stop)         nxt = S_HALT;
        else if (is_mem_ref) nxt = S_OA;
        else                 nxt = S_OPR;
      end
      S_OA:  nxt = S_OC;
      S_OC:  nxt = S_OW;
      S_OW:  nxt = S_OD;
      S_OD:  nxt = S_OA2;
      S_OA2: nxt = S_OC2;
      S_OC2: begin
        if (opcode == OP_LD)      nxt = S_LW;
        else if (opcode == OP_ST) nxt = S_SR;
        else if (branch_go(cond, zf)) nxt = S_BA;
        else                      nxt = S_FA;
      end
      S_LW:  nxt = S_LM;
      S_LM:  nxt = S_OPR;
      S_OPR: nxt = S_EXE;
      S_EXE: nxt = S_WB;
      S_WB:  nxt = S_FA;
      S_SR:  nxt = S_SW;
      S_SW:  nxt = S_FA;
      S_BA:  nxt = S_BC;
      S_BC:  nxt = S_FA;
      S_HALT: nxt = S_HALT;
      default: nxt = S_FA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FA;
    else     state <= nxt;
  end

  assign alu_fn = (state == S_EXE) ? exec_fn(opcode) : ALU_COPY;
  assign halted = (state == S_HALT);

  AST_STOP_DECODES_TO_HALT: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && opcode >= OP_HLT) |=> halted); // R10

  AST_EXEC_ONLY_FOR_ALU: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXE) |-> (opcode <= OP_LD)); // R4

endmodule

// File: rtl/acc_bus_cpu.sv
module acc_bus_cpu
  import cpu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RF_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              halted
);

  localparam int IDX_W = $clog2(RF_DEPTH);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);
  localparam int F_OP = 24;
  localparam int F_S1 = 16;
  localparam int F_S2 = 8;
  localparam int F_D  = 0;

  state_e  state;
  alu_fn_e alu_fn;

  logic [DATA_W-1:0] pc, ra, rb, rc, mar, mbr, ir;
  logic              zf;

  logic [7:0] ir_op, ir_s1, ir_s2, ir_d;
  assign ir_op = ir[F_OP +: 8];
  assign ir_s1 = ir[F_S1 +: 8];
  assign ir_s2 = ir[F_S2 +: 8];
  assign ir_d  = ir[F_D  +: 8];

  function automatic logic [IDX_W-1:0] wrap_idx(input logic [7:0] f);
    return IDX_W'(f % 8'(RF_DEPTH));
  endfunction

  logic [DATA_W-1:0] rf_a, rf_b, alu_y;
  logic              alu_zero;

  // Named internal events
  wire fetch_cap = (state == S_FI);
  wire flag_upd  = (state == S_EXE);
  wire rf_we     = (state == S_WB);
  wire st_we     = (state == S_SW);

  cpu_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (ir_op),
    .cond   (ir_s1),
    .zf     (zf),
    .state  (state),
    .alu_fn (alu_fn),
    .halted (halted)
  );

  cpu_regfile #(.DATA_W(DATA_W), .DEPTH(RF_DEPTH)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .rd_sel_a (wrap_idx(ir_s1)),
    .rd_sel_b (wrap_idx(ir_s2)),
    .wr_en    (rf_we),
    .wr_sel   (wrap_idx(ir_d)),
    .wr_data  (rc),
    .rd_a     (rf_a),
    .rd_b     (rf_b)
  );

  cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .fn       (alu_fn),
    .opa      (ra),
    .opb      (rb),
    .res      (alu_y),
    .res_zero (alu_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ra  <= '0;
      rb  <= '0;
      rc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      zf  <= 1'b0;
    end else begin
      case (state)
        S_FA:  ra <= pc;
        S_FC:  begin rc <= alu_y; mar <= alu_y; end
        S_FI:  begin ir <= mem_rdata; pc <= pc + STEP; end
        S_OA:  ra <= pc;
        S_OC:  begin rc <= alu_y; mar <= alu_y; end
        S_OD:  mbr <= mem_rdata;
        S_OA2: ra <= mbr;
        S_OC2: begin rc <= alu_y; mar <= alu_y; pc <= pc + STEP; end
        S_LM:  mbr <= mem_rdata;
        S_OPR: begin
          ra <= (ir_op == OP_LD) ? mbr : rf_a;
          rb <= rf_b;
        end
        S_EXE: begin rc <= alu_y; zf <= alu_zero; end
        S_SR:  mbr <= rf_a;
        S_BA:  ra <= mar;
        S_BC:  begin rc <= alu_y; pc <= alu_y; end
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = st_we;

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_we && $stable(mem_addr))); // R10

  AST_WRITE_ONLY_ON_STORE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (ir_op == OP_ST)); // R8

  AST_WRITE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R8

  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
    !flag_upd |=> $stable(zf)); // R6

  AST_FLAG_MATCHES_RESULT: assert property (@(posedge clk) disable iff (rst)
    flag_upd |=> (zf == (rc == '0))); // R6

  AST_WB_NOT_FOR_CONTROL: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (ir_op != OP_ST && ir_op != OP_BR && ir_op < OP_HLT)); // R4

  AST_FETCH_FROM_PC: assert property (@(posedge clk) disable iff (rst)
    fetch_cap |-> (mem_addr == pc)); // R3

endmodule

// File: tb/tb_acc_bus_cpu.sv
module tb_acc_bus_cpu;
  import cpu_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_rdata, mem_wdata;
  logic        mem_we, halted;

  logic [31:0] mem [MEM_WORDS];
  logic        ld_en = 1'b0, clr = 1'b0;
  logic [9:0]  ld_idx = '0;
  logic [31:0] ld_dat = '0;

  int checks = 0;
  int errors = 0;
  int pc_w   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_bus_cpu dut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .halted    (halted)
  );

  // Memory model: word index = byte address / 4, read data registered.
  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
    end else if (ld_en) begin
      mem[ld_idx] <= ld_dat;
    end else if (mem_we) begin
      mem[mem_addr[11:2]] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr[11:2]];
  end

  function automatic logic [31:0] ins(input logic [7:0] op, s1, s2, d);
    return {op, s1, s2, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic put(input int idx, input logic [31:0] dat);
    ld_en = 1'b1; ld_idx = 10'(idx); ld_dat = dat;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic emit(input logic [31:0] w);
    put(pc_w, w);
    pc_w++;
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst = 1'b1;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    pc_w = 0;
  endtask

  task automatic run_prog(input string name);
    int n;
    @(negedge clk);
    // R1: reset state seen at the ports
    chk({"R1 reset halted ", name}, {31'd0, halted}, 32'd0);
    chk({"R1 reset we ", name}, {31'd0, mem_we}, 32'd0);
    chk({"R1 reset addr ", name}, mem_addr, 32'd0);
    rst = 1'b0;
    n = 0;
    while (!halted && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk({"R10 halt reached ", name}, {31'd0, halted}, 32'd1);
  endtask

  // Arithmetic, logic, load, store, halt
  task automatic prog_alu();
    begin_prog();
    put(256, 32'd7);
    put(257, 32'd5);
    emit(ins(OP_LD, 0, 0, 1)); emit(32'h400);
    emit(ins(OP_LD, 0, 0, 2)); emit(32'h404);
    emit(ins(OP_ADD, 1, 2, 3));
    emit(ins(OP_SUB, 1, 2, 4));
    emit(ins(OP_SUB, 2, 1, 5));
    emit(ins(OP_AND, 1, 2, 6));
    emit(ins(OP_OR,  1, 2, 7));
    emit(ins(OP_NOT, 1, 3, 8));
    emit(ins(OP_MOV, 1, 5, 9));
    for (int r = 3; r <= 9; r++) begin
      emit(ins(OP_ST, 8'(r), 0, 0)); emit(32'h600 + 32'(4 * (r - 3)));
    end
    emit(ins(OP_ST, 1, 0, 0)); emit(32'h61C);
    emit(ins(OP_HLT, 0, 0, 0));
    emit(ins(OP_ST, 3, 0, 0)); emit(32'h620);
    run_prog("alu");
    chk("R4 R3 add", mem[384], 32'd12);
    chk("R4 sub", mem[385], 32'd2);
    chk("R4 sub wrap", mem[386], 32'hFFFF_FFFE);
    chk("R4 and", mem[387], 32'd5);
    chk("R4 R8 or stored", mem[388], 32'd7);
    chk("R5 not", mem[389], 32'hFFFF_FFF8);
    chk("R5 mov", mem[390], 32'd7);
    chk("R7 R2 load", mem[391], 32'd7);
    chk("R10 no run past halt", mem[392], 32'd0);
  endtask

  // Branch conditions and zero flag persistence
  task automatic prog_branch();
    int loop_at, tgt;
    begin_prog();
    put(256, 32'd3);
    put(257, 32'd1);
    put(258, 32'd0);
    put(259, 32'h0000_0BAD);
    // trap routine at byte 0x300
    pc_w = 192;
    emit(ins(OP_LD, 0, 0, 4)); emit(32'h40C);
    emit(ins(OP_ST, 4, 0, 0)); emit(32'h700);
    emit(ins(OP_HLT, 0, 0, 0));
    pc_w = 0;
    emit(ins(OP_LD, 0, 0, 1)); emit(32'h400);
    emit(ins(OP_LD, 0, 0, 2)); emit(32'h404);
    loop_at = pc_w * 4;
    emit(ins(OP_ADD, 2, 3, 3));
    emit(ins(OP_SUB, 1, 2, 1));
    emit(ins(OP_BR, COND_NZERO, 0, 0)); emit(32'(loop_at));
    emit(ins(OP_ST, 1, 0, 0)); emit(32'h600);
    emit(ins(OP_ST, 3, 0, 0)); emit(32'h604);
    // flag still set after stores: skip the trap jump
    tgt = (pc_w + 4) * 4;
    emit(ins(OP_BR, COND_ZERO, 0, 0)); emit(32'(tgt));
    emit(ins(OP_BR, COND_ALWAYS, 0, 0)); emit(32'h300);
    emit(ins(OP_BR, COND_NZERO, 0, 0)); emit(32'h300);
    emit(ins(OP_BR, 8'd3, 0, 0)); emit(32'h300);
    tgt = (pc_w + 4) * 4;
    emit(ins(OP_BR, COND_ALWAYS, 0, 0)); emit(32'(tgt));
    emit(ins(OP_BR, COND_ALWAYS, 0, 0)); emit(32'h300);
    emit(ins(OP_MOV, 0, 0, 5));
    emit(ins(OP_MOV, 2, 0, 6));
    emit(ins(OP_BR, COND_ZERO, 0, 0)); emit(32'h300);
    emit(ins(OP_ST, 6, 0, 0)); emit(32'h608);
    emit(ins(OP_LD, 0, 0, 7)); emit(32'h408);
    emit(ins(OP_BR, COND_NZERO, 0, 0)); emit(32'h300);
    emit(ins(OP_HLT, 0, 0, 0));
    run_prog("branch");
    chk("R9 loop result", mem[384], 32'd0);
    chk("R9 loop count", mem[385], 32'd3);
    chk("R6 R5 mov copy", mem[386], 32'd1);
    chk("R9 R6 no trap taken", mem[448], 32'd0);
  endtask

  // Index aliasing, undefined opcode halt, idle after halt
  task automatic prog_wrap();
    logic [31:0] held;
    bit ok;
    begin_prog();
    put(256, 32'h1234_5678);
    emit(ins(OP_LD, 0, 0, 8'd33)); emit(32'h400);
    emit(ins(OP_ST, 8'd65, 0, 0)); emit(32'h600);
    emit(ins(OP_ADD, 8'h21, 8'h20, 8'h42));
    emit(ins(OP_ST, 2, 0, 0)); emit(32'h604);
    emit(ins(8'h0C, 0, 0, 0));
    emit(ins(OP_ST, 1, 0, 0)); emit(32'h608);
    run_prog("wrap");
    chk("R11 load alias", mem[384], 32'h1234_5678);
    chk("R11 add alias", mem[385], 32'h1234_5678);
    chk("R10 undefined op halts", mem[386], 32'd0);
    held = mem_addr;
    ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!halted || mem_we || mem_addr !== held) ok = 1'b0;
    end
    chk("R10 idle while halted", {31'd0, ok}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    prog_alu();
    prog_branch();
    prog_wrap();
    summary();
  end

endmodule